// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire PHY management bus. It generates the management clock (MDC) from the system clock and serialises frames onto the data line through separate output, output-enable and input pins, so the pad tristate sits outside the block. One register set serves both the legacy 5-bit register frame and the extended indirect frame. A mode bit in the configuration word selects between them.

Software starts each kind of transaction with its own register action. A write to the address word starts an address frame, but only in extended mode. A write to the data word starts a write frame. A control write with the read bit set starts a read frame. Two busy flags report progress. The configuration busy flag covers every frame. The busy flag in the data word covers only write and read frames.

Register map, selected by `reg_sel`:
- Select 0, configuration/status: bit 0 is busy (read-only), bit 1 is the read-error flag (read-only), bit 4 selects extended mode, bit 5 selects the drive edge, and bits [16+DIV_W-1:16] hold the clock divider.
- Select 1, control: bits [9:5] hold the PHY address, bits [4:0] hold the device or register number, and bit 15 is the read trigger. The read trigger always reads back as 0.
- Select 2, address: bits [15:0].
- Select 3, data: bits [15:0] hold the value, and bit 31 is the transfer busy flag.

Top module: `mdio_master`

## Requirements
- R1: After reset the configuration word reads 0x0000_0020: drive-edge bit 1, extended mode 0, divider 0, busy 0 and read error 0. The output enable is low whenever no frame is active.
- R2: Every frame is 64 bits, sent MSB first, in this order:
  - 32 ones;
  - the start code: 01 in legacy mode, 00 in extended mode;
  - a 2-bit opcode: legacy write 01 and read 10; extended address 00, write 01 and read 11;
  - the 5-bit PHY address, then the 5-bit device or register field;
  - turnaround 10, driven on non-read frames;
  - 16 payload bits. The payload is the address word for address frames and the data word for write frames.
- R3: While a frame is active, MDC toggles every `div` system clocks, so each bit takes 2*div clocks. MDC idles low when the drive-edge bit is 1 and high when it is 0. In each bit, the first MDC toggle is the sample point. The line changes only on the second toggle.
- R4: A divider of 0 freezes MDC and frame progress. Busy stays set until a nonzero divider is written. The configuration word stays writable while busy.
- R5: Writing the address word starts an address frame only when extended mode is set. In legacy mode the value is only stored, and no frame starts.
- R6: Writing the data word stores the value and starts a write frame. Data-word bit 31 stays set until the last bit has been sent.
- R7: A control write with bit 15 set starts a read frame using the written PHY and device fields. The output enable drops at the first turnaround bit and stays low to the end of the frame. The 16 sampled bits land in data[15:0] when the frame ends.
- R8: In a read frame, a 1 sampled in the second turnaround bit sets configuration bit 1. Starting a read frame clears that bit. Address and write frames leave it unchanged.
- R9: While busy, writes to the control, address and data words are ignored. No frame starts and the stored values are unchanged.
- R10: Busy is visible from the cycle after the accepting clock edge. Configuration bit 0 is set for every frame type. Data-word bit 31 is set only for write and read frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 cfg, 1 ctl, 2 addr, 3 data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Line output value |
| mdio_oe | output | 1 | Line output enable |
| mdio_i | input | 1 | Line input value |

## Verification
The assertions check, on every cycle:
- that the idle line is released and MDC rests at its idle level;
- that a zero divider freezes the bit counter and the clock;
- that the driven bit never changes in the first half of a bit;
- that the bit position advances one step at a time;
- that the output enable falls mid-frame only at the first turnaround bit of a read;
- that locked fields keep their values during busy writes.

The exact frame bits for each mode and opcode cannot be shown by a property. Neither can the captured read value, the read-error outcome or the silent drop of triggers issued while busy. The bench shows these through its per-clock reference model and a PHY responder that can answer or stay silent.

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master #(
  parameter int DIV_W = 9,
  parameter logic [DIV_W-1:0] DIV_RST = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRM = 64;
  localparam int CW = $clog2(FRM);
  localparam logic [CW-1:0] TA_BIT  = CW'(46);
  localparam logic [CW-1:0] TA_CHK  = CW'(47);
  localparam logic [CW-1:0] DAT_BIT = CW'(48);
  localparam logic [CW-1:0] LAST    = CW'(FRM - 1);
  localparam int RD_BIT = 15;

  logic [DIV_W-1:0] div_r, ckcnt;
  logic             c45_r, edge_r, rderr_r;
  logic [4:0]       port_r, dev_r;
  logic [15:0]      addr_r, data_r, rdsh;
  logic             active, ph, is_rd, is_dat;
  logic [CW-1:0]    bitcnt;
  logic [FRM-1:0]   sh;

  logic wr_cfg, wr_ctl, wr_adr, wr_dat;
  logic go_rd, go_adr, go_wr, go, tick;
  logic [4:0]  f_port, f_dev;
  logic [1:0]  f_st, f_op;
  logic [15:0] f_pay;
  logic [FRM-1:0] f_frame;
  logic [31:0] stat_w;
  logic unused_bits;

  assign wr_cfg = reg_wr && (reg_sel == 2'd0);
  assign wr_ctl = reg_wr && (reg_sel == 2'd1);
  assign wr_adr = reg_wr && (reg_sel == 2'd2);
  assign wr_dat = reg_wr && (reg_sel == 2'd3);

  assign go_rd  = wr_ctl && reg_wdata[RD_BIT] && !active;
  assign go_adr = wr_adr && c45_r && !active;
  assign go_wr  = wr_dat && !active;
  assign go     = go_rd || go_adr || go_wr;

  assign f_port  = wr_ctl ? reg_wdata[9:5] : port_r;
  assign f_dev   = wr_ctl ? reg_wdata[4:0] : dev_r;
  assign f_st    = c45_r ? 2'b00 : 2'b01;
  assign f_op    = go_rd ? {1'b1, c45_r} : {1'b0, go_wr};
  assign f_pay   = go_rd ? 16'hFFFF : reg_wdata[15:0];
  assign f_frame = {{32{1'b1}}, f_st, f_op, f_port, f_dev, 2'b10, f_pay};

  assign tick = active && (div_r != '0) && (ckcnt >= div_r - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_r  <= DIV_RST;
      c45_r  <= 1'b0;
      edge_r <= 1'b1;
      port_r <= '0;
      dev_r  <= '0;
      addr_r <= '0;
    end else begin
      if (wr_cfg) begin
        div_r  <= reg_wdata[16 +: DIV_W];
        c45_r  <= reg_wdata[4];
        edge_r <= reg_wdata[5];
      end
      if (wr_ctl && !active) begin
        port_r <= reg_wdata[9:5];
        dev_r  <= reg_wdata[4:0];
      end
      if (wr_adr && !active) addr_r <= reg_wdata[15:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      ph      <= 1'b0;
      ckcnt   <= '0;
      bitcnt  <= '0;
      sh      <= '0;
      is_rd   <= 1'b0;
      is_dat  <= 1'b0;
      rderr_r <= 1'b0;
      rdsh    <= '0;
      data_r  <= '0;
    end else if (go) begin
      active <= 1'b1;
      ph     <= 1'b0;
      ckcnt  <= '0;
      bitcnt <= '0;
      sh     <= f_frame;
      is_rd  <= go_rd;
      is_dat <= go_rd || go_wr;
      if (go_rd) rderr_r <= 1'b0;
      if (go_wr) data_r <= reg_wdata[15:0];
    end else if (active && (div_r != '0)) begin
      if (!tick) begin
        ckcnt <= ckcnt + 1'b1;
      end else begin
        ckcnt <= '0;
        ph    <= ~ph;
        if (!ph) begin
          if (is_rd && (bitcnt == TA_CHK) && mdio_i) rderr_r <= 1'b1;
          if (is_rd && (bitcnt >= DAT_BIT)) rdsh <= {rdsh[14:0], mdio_i};
        end else if (bitcnt == LAST) begin
          active <= 1'b0;
          if (is_rd) data_r <= rdsh;
        end else begin
          bitcnt <= bitcnt + 1'b1;
          sh     <= {sh[FRM-2:0], 1'b0};
        end
      end
    end
  end

  assign mdc     = ph ^ ~edge_r;
  assign mdio_o  = sh[FRM-1];
  assign mdio_oe = active && !(is_rd && (bitcnt >= TA_BIT));

  always_comb begin
    stat_w = '0;
    stat_w[0] = active;
    stat_w[1] = rderr_r;
    stat_w[4] = c45_r;
    stat_w[5] = edge_r;
    stat_w[16 +: DIV_W] = div_r;
  end

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = stat_w;
      2'd1:    reg_rdata = {22'd0, port_r, dev_r};
      2'd2:    reg_rdata = {16'd0, addr_r};
      default: reg_rdata = {active && is_dat, 15'd0, data_r};
    endcase
  end

  assign unused_bits = ^reg_wdata;
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk #(
  parameter int DIV_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic             ph,
  input logic [5:0]       bitcnt,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             edge_r,
  input logic [DIV_W-1:0] div_r,
  input logic             is_rd,
  input logic [15:0]      addr_r,
  input logic [4:0]       port_r,
  input logic [4:0]       dev_r,
  input logic             reg_wr,
  input logic [1:0]       reg_sel
);
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mdio_oe); // R1
  AST_IDLE_MDC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (mdc == !edge_r)); // R3
  AST_DIV0_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (div_r == '0) && !(reg_wr && (reg_sel == 2'd0))) |=> ($stable(bitcnt) && $stable(mdc))); // R4
  AST_MDO_FIRST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(ph)) |-> $stable(mdio_o)); // R3
  AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> ((bitcnt == $past(bitcnt)) || (bitcnt == $past(bitcnt) + 6'd1))); // R2
  AST_OE_DROP_AT_TA: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mdio_oe) && active) |-> (is_rd && (bitcnt == 6'd46))); // R7
  AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (active && reg_wr && (reg_sel == 2'd2)) |=> $stable(addr_r)); // R9
  AST_CTL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (active && reg_wr && (reg_sel == 2'd1)) |=> ($stable(port_r) && $stable(dev_r))); // R9
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .ph(ph), .bitcnt(bitcnt),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .edge_r(edge_r),
  .div_r(div_r), .is_rd(is_rd), .addr_r(addr_r), .port_r(port_r),
  .dev_r(dev_r), .reg_wr(reg_wr), .reg_sel(reg_sel)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic mdio_in = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bit m_act, m_rd, m_edge, m_c45, phy_on;
  int m_h, m_cnt, m_div;
  logic [4:0] m_port, m_dev;
  logic [15:0] m_addr, m_data, m_cap, phy_val;
  logic [63:0] m_frame;

  always #10 clk = ~clk;

  mdio_master u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_start(input logic [1:0] op, input logic [15:0] pay, input bit rd);
    m_frame = {32'hFFFF_FFFF, (m_c45 ? 2'b00 : 2'b01), op, m_port, m_dev, 2'b10, pay};
    m_act = 1; m_h = 0; m_cnt = 0; m_rd = rd;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_rd = 0; m_h = 0; m_cnt = 0; m_div = 0; m_edge = 1; m_c45 = 0;
      m_port = 0; m_dev = 0; m_addr = 0; m_data = 0; m_cap = 0; m_frame = 0;
    end else begin
      automatic bit a0 = m_act;
      if (m_act && m_div != 0) begin
        if (m_cnt >= m_div - 1) begin
          m_cnt = 0;
          if (m_h % 2 == 0) begin
            if (m_rd && m_h / 2 >= 48) m_cap = {m_cap[14:0], mdio_in};
          end else if (m_h == 127) begin
            m_act = 0;
            if (m_rd) m_data = m_cap;
          end
          m_h++;
        end else m_cnt++;
      end
      if (reg_wr) begin
        case (reg_sel)
          2'd0: begin m_div = int'(reg_wdata[24:16]); m_edge = reg_wdata[5]; m_c45 = reg_wdata[4]; end
          2'd1: if (!a0) begin
            m_port = reg_wdata[9:5]; m_dev = reg_wdata[4:0];
            if (reg_wdata[15]) m_start(m_c45 ? 2'b11 : 2'b10, 16'hFFFF, 1);
          end
          2'd2: if (!a0) begin
            m_addr = reg_wdata[15:0];
            if (m_c45) m_start(2'b00, m_addr, 0);
          end
          default: if (!a0) begin
            m_data = reg_wdata[15:0];
            m_start(2'b01, m_data, 0);
          end
        endcase
      end
    end
  end

  function automatic logic phy_line();
    int b;
    if (!(m_act && m_rd)) return 1'b1;
    b = m_h / 2;
    if (b == 47) return phy_on ? 1'b0 : 1'b1;
    if (b >= 48) return phy_on ? phy_val[15 - (b - 48)] : 1'b1;
    return 1'b1;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      automatic logic e_mdc = m_act ? ((m_h % 2 == 1) ? m_edge : !m_edge) : !m_edge;
      automatic logic e_oe = m_act && !(m_rd && (m_h / 2 >= 46));
      chk(mdc == e_mdc, "R3 mdc", {31'd0, mdc}, {31'd0, e_mdc});
      chk(mdio_oe == e_oe, "R7 oe", {31'd0, mdio_oe}, {31'd0, e_oe});
      if (e_oe) chk(mdio_o == m_frame[63 - m_h / 2], "R2 frame bit", {31'd0, mdio_o}, {31'd0, m_frame[63 - m_h / 2]});
    end
    mdio_in = mdio_oe ? mdio_o : phy_line();
  end

  task automatic bus_wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd0, v);
      if (!v[0]) return;
    end
  endtask

  function automatic logic [31:0] cfg(input int dv, input bit ed, input bit c45);
    return (32'(dv) << 16) | (32'(ed) << 5) | (32'(c45) << 4);
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL R6 watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    phy_on = 1; phy_val = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, v); chk(v == 32'h0000_0020, "R1 cfg reset", v, 32'h20);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle pins", {30'd0, mdc, mdio_oe}, 32'd0);

    bus_wr(2'd3, 32'h1357);
    rd(2'd0, v); chk(v[0] == 1'b1, "R10 cfg busy", v, 32'h1);
    rd(2'd3, v); chk(v == 32'h8000_1357, "R6 data busy", v, 32'h8000_1357);
    repeat (40) @(negedge clk);
    rd(2'd0, v); chk(v[0] == 1'b1 && mdc == 1'b0, "R4 frozen", v, 32'h1);
    bus_wr(2'd0, cfg(2, 1, 0));
    wait_idle();
    rd(2'd3, v); chk(v == 32'h0000_1357, "R6 write done", v, 32'h1357);

    phy_val = 16'hA5C3;
    bus_wr(2'd1, 32'h8000 | (3 << 5) | 7);
    rd(2'd3, v); chk(v[31] == 1'b1, "R10 read busy", v, 32'h8000_0000);
    wait_idle();
    rd(2'd3, v); chk(v == 32'h0000_A5C3, "R7 read value", v, 32'hA5C3);
    rd(2'd0, v); chk(v[1] == 1'b0, "R8 no error", v, 32'h0);
    rd(2'd1, v); chk(v == 32'h67, "R7 ctl readback", v, 32'h67);

    phy_on = 0;
    bus_wr(2'd1, 32'h8000 | (3 << 5) | 7);
    wait_idle();
    rd(2'd0, v); chk(v[1] == 1'b1, "R8 error set", v, 32'h2);
    rd(2'd3, v); chk(v == 32'h0000_FFFF, "R8 absent ones", v, 32'hFFFF);

    bus_wr(2'd0, cfg(3, 0, 1));
    rd(2'd0, v); chk(mdc == 1'b1, "R3 idle high", {31'd0, mdc}, 32'h1);
    bus_wr(2'd2, 32'h1234);
    rd(2'd0, v); chk(v[0] == 1'b1, "R10 addr busy", v, 32'h1);
    rd(2'd3, v); chk(v[31] == 1'b0, "R10 addr no data busy", v, 32'h0000_FFFF);
    bus_wr(2'd3, 32'hBEEF);
    bus_wr(2'd2, 32'h5555);
    bus_wr(2'd1, 32'h8000 | (9 << 5) | 9);
    wait_idle();
    repeat (20) @(negedge clk);
    rd(2'd0, v); chk(v[0] == 1'b0, "R9 no late frame", v, 32'h0);
    chk(v[1] == 1'b1, "R8 kept by addr frame", v, 32'h2);
    rd(2'd2, v); chk(v == 32'h1234, "R9 addr kept", v, 32'h1234);
    rd(2'd3, v); chk(v == 32'hFFFF, "R9 data kept", v, 32'hFFFF);
    rd(2'd1, v); chk(v == 32'h67, "R9 ctl kept", v, 32'h67);

    bus_wr(2'd3, 32'h0F0F);
    wait_idle();
    rd(2'd3, v); chk(v == 32'h0F0F, "R6 c45 write", v, 32'h0F0F);

    phy_on = 1; phy_val = 16'h3C5A;
    bus_wr(2'd1, 32'h8000 | (5 << 5) | 2);
    rd(2'd0, v); chk(v[1] == 1'b0, "R8 cleared on read", v, 32'h0);
    wait_idle();
    rd(2'd3, v); chk(v == 32'h3C5A, "R7 c45 read", v, 32'h3C5A);

    bus_wr(2'd0, cfg(2, 1, 0));
    bus_wr(2'd2, 32'h0042);
    rd(2'd0, v); chk(v[0] == 1'b0, "R5 no frame in legacy", v, 32'h0);
    repeat (10) @(negedge clk);
    chk(mdio_oe == 1'b0, "R5 line idle", {31'd0, mdio_oe}, 32'h0);
    rd(2'd2, v); chk(v == 32'h42, "R5 addr stored", v, 32'h42);

    finished = 1;
    summary();
    $finish;
  end
endmodule